// File: doc/BRIEF.md
# Indexed Register Write Buffer

This block is a small write buffer for one thread lane. It sits in front of a slow, non-volatile main register store. Writes land in the buffer and not in the main store. Lookup needs no search: a control table with one slot per register number holds a valid flag and a pointer into a compact data store. The data store fills from entry 0 upward, in allocation order. Each data entry keeps the register value and the register number it belongs to, so a later drain stage can walk the occupied prefix.

A read sends its address to the main store and to the control table in the same cycle. One cycle later the output carries the buffered copy when the register is held in the buffer, and the main store's reply otherwise. When a new warp becomes active, a clear input empties the table and restarts allocation at entry 0. An occupancy count reports how many data entries are in use.

Top module: `reg_wr_buffer`

## Requirements
- R1: After reset the occupancy count is 0 and the read-source flag is 0. A read of any register then returns the main store's reply.
- R2: A write to a register not held in the buffer takes data entry number equal to the current occupancy count and raises the count by one.
- R3: A write to a register already held overwrites its existing entry and leaves the count unchanged. A later read returns the newest data.
- R4: A read of a held register drives the buffered value on the read data output, with the read-source flag at 1, in the cycle after the address is presented.
- R5: The main store address output equals the read address in the same cycle. For a register not held, the read data in the next cycle is the value the main store returns in that cycle, and the read-source flag is 0.
- R6: A read and a write to the same register in the same cycle return the value from before that write. The written data appears on reads from the next cycle on.
- R7: A clear empties the buffer. From the next cycle the count is 0 and every read returns main store data. A read issued in the clear cycle itself still sees the contents from before the clear.
- R8: A write in the same cycle as a clear goes into the emptied buffer at entry 0, and the count becomes 1.
- R9: Writing every register number once brings the count to the data store depth, 64 by default. After that every read hits the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Empty the buffer (new warp activated) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register number written |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 6 | Register number read |
| main_rd_addr_o | output | 6 | Read address forwarded to the main store |
| main_rd_data_i | input | 32 | Main store reply, one cycle after its address |
| rd_data_o | output | 32 | Read result, one cycle after rd_addr_i |
| rd_hit_o | output | 1 | 1 when rd_data_o comes from the buffer |
| used_o | output | 7 | Number of occupied data entries |

## Verification
The bench targets a read and a write to the same register in one cycle. A design that forwarded the new data, or that looked up a table already updated, would return the new value instead of the old one. It also targets a write that coincides with a clear. Here a wrong priority would either lose the write or place it at the old fill position, leaving the count at a value other than 1. Repeated writes to one register check that a hit never allocates, since extra allocation would inflate the count and strand stale entries. A full fill of all register numbers checks that the count reaches 64 and that entry 63 is reached without the index wrapping.

// File: rtl/rwb_pkg.sv
`timescale 1ns/1ps
package rwb_pkg;
   localparam int unsigned RWB_DATA_W = 32;
   localparam int unsigned RWB_ADDR_W = 6;
   localparam int unsigned RWB_DEPTH  = 64;

   function automatic int unsigned rwb_cnt_w(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/rwb_ctrl_tbl.sv
`timescale 1ns/1ps
module rwb_ctrl_tbl #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned IDX_W  = 6,
   localparam int unsigned NREGS = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [IDX_W-1:0]  alloc_idx_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic              wr_hit_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output logic              rd_hit_o,
   output logic [IDX_W-1:0]  rd_idx_o
);
   logic [NREGS-1:0] valid_q;
   logic [IDX_W-1:0] idx_q [NREGS];
   logic [NREGS-1:0] new_sel;

   // a clear in the same cycle hides the old contents from the write
   assign wr_hit_o = valid_q[wr_addr_i] & ~clr_i;
   assign wr_idx_o = idx_q[wr_addr_i];
   assign rd_hit_o = valid_q[rd_addr_i];
   assign rd_idx_o = idx_q[rd_addr_i];

   for (genvar g = 0; g < NREGS; g++) begin : g_sel
      assign new_sel[g] = wr_en_i & ~wr_hit_o & (wr_addr_i == ADDR_W'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else begin
         for (int i = 0; i < NREGS; i++) begin
            if (new_sel[i])  valid_q[i] <= 1'b1;
            else if (clr_i)  valid_q[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NREGS; i++) begin
         if (new_sel[i]) idx_q[i] <= alloc_idx_i;
      end
   end

   AST_ALLOC_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !wr_hit_o) |=> valid_q[$past(wr_addr_i)]);   // R2
   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !wr_en_i) |=> (valid_q == '0));                // R7
endmodule

// File: rtl/rwb_data_store.sv
`timescale 1ns/1ps
module rwb_data_store #(
   parameter int unsigned ENT_W = 38,
   parameter int unsigned DEPTH = 64,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [IDX_W-1:0] widx_i,
   input  logic [ENT_W-1:0] wentry_i,
   input  logic [IDX_W-1:0] ridx_i,
   output logic [ENT_W-1:0] rentry_o
);
   logic [ENT_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem_q[widx_i] <= wentry_i;
   end

   // registered read samples the array before this edge's write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rentry_o <= '0;
      else        rentry_o <= mem_q[ridx_i];
   end
endmodule

// File: rtl/rwb_fill_cnt.sv
`timescale 1ns/1ps
module rwb_fill_cnt #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned IDX_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             alloc_i,
   output logic [IDX_W-1:0] alloc_idx_o,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] base;

   assign base        = clr_i ? '0 : cnt_o;
   assign alloc_idx_o = base[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_o <= '0;
      else        cnt_o <= base + CNT_W'(alloc_i);
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o <= CNT_W'(DEPTH));                                             // R9
   AST_MISS_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_i && !clr_i) |=> (cnt_o == $past(cnt_o) + 1'b1));             // R2
   AST_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!alloc_i && !clr_i) |=> $stable(cnt_o));                             // R3
   AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_o == CNT_W'($past(alloc_i))));                         // R8
endmodule

// File: rtl/reg_wr_buffer.sv
`timescale 1ns/1ps
module reg_wr_buffer
   import rwb_pkg::*;
#(
   parameter int unsigned DATA_W = RWB_DATA_W,
   parameter int unsigned ADDR_W = RWB_ADDR_W,
   parameter int unsigned DEPTH  = RWB_DEPTH,
   localparam int unsigned IDX_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = rwb_cnt_w(DEPTH),
   localparam int unsigned ENT_W = DATA_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [ADDR_W-1:0] main_rd_addr_o,
   input  logic [DATA_W-1:0] main_rd_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_hit_o,
   output logic [CNT_W-1:0]  used_o
);
   // every register must fit, so the buffer can never overflow
   if (DEPTH < (1 << ADDR_W)) begin : g_bad_depth
      initial $error("DEPTH must cover all register numbers");
   end
   if (DATA_W == 0) begin : g_bad_width
      initial $error("DATA_W must be nonzero");
   end

   logic             wr_hit, rd_hit_c, alloc;
   logic [IDX_W-1:0] wr_idx, rd_idx, alloc_idx, widx;
   logic [ENT_W-1:0] rentry;
   logic [ADDR_W-1:0] rd_addr_q;

   rwb_ctrl_tbl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_tbl (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .alloc_idx_i(alloc_idx),
      .rd_addr_i(rd_addr_i),
      .wr_hit_o(wr_hit), .wr_idx_o(wr_idx),
      .rd_hit_o(rd_hit_c), .rd_idx_o(rd_idx)
   );

   assign alloc = wr_en_i & ~wr_hit;
   assign widx  = wr_hit ? wr_idx : alloc_idx;

   rwb_fill_cnt #(.DEPTH(DEPTH)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .alloc_i(alloc),
      .alloc_idx_o(alloc_idx), .cnt_o(used_o)
   );

   rwb_data_store #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .rst_n(rst_n), .we_i(wr_en_i), .widx_i(widx),
      .wentry_i({wr_addr_i, wr_data_i}), .ridx_i(rd_idx), .rentry_o(rentry)
   );

   assign main_rd_addr_o = rd_addr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_hit_o  <= 1'b0;
         rd_addr_q <= '0;
      end else begin
         rd_hit_o  <= rd_hit_c;
         rd_addr_q <= rd_addr_i;
      end
   end

   assign rd_data_o = rd_hit_o ? rentry[DATA_W-1:0] : main_rd_data_i;

   AST_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit_o |-> (rentry[ENT_W-1:DATA_W] == rd_addr_q));                 // R4
   AST_MISS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit_o |-> (rd_data_o == main_rd_data_i));                         // R5
endmodule

// File: tb/reg_wr_buffer_tb_top.sv
`timescale 1ns/1ps
module reg_wr_buffer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr_i = 1'b0, wr_en_i = 1'b0;
   logic [5:0]  wr_addr_i = '0, rd_addr_i = '0, main_rd_addr_o;
   logic [31:0] wr_data_i = '0, main_rd_data_i = '0, rd_data_o;
   logic        rd_hit_o;
   logic [6:0]  used_o;

   int n_run = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   logic        m_valid [64];
   logic [31:0] m_data  [64];
   int          m_used;

   always #2.5 clk = ~clk;

   reg_wr_buffer dut_i (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .wr_en_i(wr_en_i),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
      .main_rd_addr_o(main_rd_addr_o), .main_rd_data_i(main_rd_data_i),
      .rd_data_o(rd_data_o), .rd_hit_o(rd_hit_o), .used_o(used_o)
   );

   function automatic logic [31:0] main_val(input logic [5:0] a);
      return 32'hC0DE_0000 | {26'd0, a} | ({26'd0, a} << 20);
   endfunction

   // single-cycle main store model
   always @(posedge clk) main_rd_data_i <= main_val(main_rd_addr_o);

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: run hung, act=%0d exp<150000", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic step(input bit we, input logic [5:0] wa, input logic [31:0] wd,
                       input logic [5:0] ra, input bit clr, input string req);
      logic        e_hit;
      logic [31:0] e_dat;
      @(negedge clk);
      wr_en_i = we; wr_addr_i = wa; wr_data_i = wd; rd_addr_i = ra; clr_i = clr;
      #0.1;
      chk({req, " R5 main addr"}, {26'd0, main_rd_addr_o}, {26'd0, ra});
      e_hit = m_valid[ra];
      e_dat = e_hit ? m_data[ra] : main_val(ra);
      if (clr) begin
         for (int i = 0; i < 64; i++) m_valid[i] = 1'b0;
         m_used = 0;
      end
      if (we) begin
         if (!m_valid[wa]) begin m_valid[wa] = 1'b1; m_used++; end
         m_data[wa] = wd;
      end
      @(negedge clk);
      wr_en_i = 1'b0; clr_i = 1'b0;
      chk({req, " hit flag"}, {31'd0, rd_hit_o}, {31'd0, e_hit});
      chk({req, " rd data"}, rd_data_o, e_dat);
      chk({req, " count"}, {25'd0, used_o}, m_used);
   endtask

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < 64; i++) begin m_valid[i] = 1'b0; m_data[i] = '0; end
      m_used = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset count", {25'd0, used_o}, 32'd0);
      chk("R1 reset hit", {31'd0, rd_hit_o}, 32'd0);
      step(0, 6'd0, 0, 6'd17, 0, "R1 read after reset");
      // R2 allocation and R4 hit
      step(1, 6'd5, 32'h1111_0005, 6'd5, 0, "R6 same-cycle miss");
      step(0, 6'd0, 0, 6'd5, 0, "R4 read hit");
      step(1, 6'd9, 32'h2222_0009, 6'd3, 0, "R2 second alloc");
      // R3 overwrite, R6 same-cycle old value
      step(1, 6'd5, 32'h3333_0005, 6'd5, 0, "R6 same-cycle hit");
      step(0, 6'd0, 0, 6'd5, 0, "R3 overwrite visible");
      step(1, 6'd5, 32'h4444_0005, 6'd9, 0, "R3 count held");
      // R7 clear: read in clear cycle sees old, then misses
      step(0, 6'd0, 0, 6'd9, 1, "R7 read in clear cycle");
      step(0, 6'd0, 0, 6'd9, 0, "R7 read after clear");
      // R8 write with clear
      step(1, 6'd40, 32'h5555_0028, 6'd40, 1, "R8 write with clear");
      step(0, 6'd0, 0, 6'd40, 0, "R8 landed");
      step(1, 6'd41, 32'h6666_0029, 6'd5, 0, "R8 next alloc");
      // R9 fill every register
      step(0, 6'd0, 0, 6'd0, 1, "R9 pre-clear");
      for (int i = 0; i < 64; i++)
         step(1, 6'(63 - i), $urandom, 6'(i), 0, "R9 fill");
      for (int i = 0; i < 64; i++)
         step(0, 6'd0, 0, 6'(i), 0, "R9 full read");
      // constrained random mix
      for (int k = 0; k < 3000; k++) begin
         bit          we  = ($urandom % 4) != 0;
         bit          clr = ($urandom % 97) == 0;
         logic [5:0]  wa  = 6'($urandom % 12);
         logic [5:0]  ra  = ($urandom % 3 == 0) ? wa : 6'($urandom % 16);
         step(we, wa, $urandom, ra, clr, "R2/R3/R4/R5 random");
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule